// File: doc/BRIEF.md
# Product-Term Logic Cell

This block is one logic cell of a sum-of-products programmable fabric. A vector of array inputs feeds five AND terms. Each term is shaped by a per-literal mask that can require a true input, a complemented input, or both. Chosen terms, plus an optional cascade input from a neighbouring cell, are ORed into a sum. The sum passes an XOR stage whose second input gives polarity control or pulls in a product term. The result, a term, or the pin input then feeds one register. Static mode bits make that register act as a D, T, JK or SR flip-flop or as a transparent latch.

Any product term can act as a control for the register: a clock source, a clock enable, a clear, a preset, the JK/SR second input, the output enable, or the inverted foldback term. Every control is chosen by a small index field. The register samples its clock sources against the block clock `clk`. A clock event is a rising transition of the selected source, seen between two `clk` edges. Clear and preset act on the register output in the same cycle they are active. The pin output and the feedback each choose, independently, between the register and the combinational XOR result.

Top module: `pterm_macrocell`

## Requirements
- R1: Term k is the AND of every `arr_in` bit selected in `cfg_tru` slice k (bits k*N_IN upward) and every inverted `arr_in` bit selected in the matching `cfg_cmp` slice. A term with no literals selected is 1. Wherever a product-term index field holds a value of NPT or more, the term it picks reads as 0.
- R2: `fold_out` is the inverse of the term picked by `cfg_fold_pt`.
- R3: `cas_out` is the OR of the terms whose `cfg_or_en` bit is set, ORed with `cas_in` when `cfg_cas_en` is 1.
- R4: The XOR result is the sum XOR a second operand. `cfg_xor_sel` 0 selects constant 0, 1 selects constant 1, and 2 or 3 selects the term picked by `cfg_xor_pt`.
- R5: Register data comes from `cfg_d_sel`: 0 takes the XOR result, 1 takes the term picked by `cfg_d_pt`, and 2 or 3 takes `pin_in`.
- R6: On a clock event the stored bit follows `cfg_mode`. Mode 0 loads data (D). Mode 1 toggles when data is 1 (T). Mode 2 is JK, with J as data and K as the `cfg_aux_pt` term: 10 sets, 01 clears, 11 toggles, 00 holds. Mode 3 is SR, with S as data and R as the aux term: S alone sets, R alone clears, both or neither hold. Codes 5 to 7 act as D.
- R7: `cfg_clk_sel` 0 to 2 picks `gclk[sel]`, and 3 picks the term picked by `cfg_clk_pt`. A clock event occurs at a `clk` edge where the selected source is 1 and was 0 at the previous `clk` edge. The stored bit changes at that edge.
- R8: In mode 4 (latch), while the selected source is 1 and enabled, the register output follows data in the same cycle and the stored bit takes data at each `clk` edge. While the source is 0 the bit holds.
- R9: With `cfg_ce_en` set and a global clock selected, clock events and latch transparency are ignored while the term picked by `cfg_ce_pt` is 0. With the term clock selected, the enable has no effect.
- R10: `cfg_ar_sel` sets the clear: 0 none, 1 `gclr`, 2 the `cfg_ar_pt` term, 3 the OR of the two. `cfg_ap_en` enables a preset from the `cfg_ap_pt` term. An active clear forces the register output to 0 in the same cycle and the stored bit to 0. An active preset forces 1. Clear wins over preset, and both override clock and latch.
- R11: `pin_out` is the register output when `cfg_out_reg` is 1, else the XOR result. `fb_out` makes the same choice from `cfg_fb_reg`, independently.
- R12: `pin_oe` follows `cfg_oe_sel`: 0 gives 1, 1 gives 0, 2 gives `goe[0]`, 3 gives `goe[1]`, and 4 to 7 give the term picked by `cfg_oe_pt`.
- R13: While `rst_n` is 0 the stored bit and the clock source history are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | block clock that samples all sources |
| rst_n | input | 1 | active-low reset |
| arr_in | input | N_IN (8) | array inputs to the AND terms |
| pin_in | input | 1 | pin value usable as register data |
| cas_in | input | 1 | cascade sum from the neighbouring cell |
| gclk | input | N_GCLK (3) | global clock source levels |
| gclr | input | 1 | global clear |
| goe | input | 2 | global output enables |
| cfg_tru | input | NPT*N_IN (40) | true-literal masks, one slice per term |
| cfg_cmp | input | NPT*N_IN (40) | complement-literal masks, one slice per term |
| cfg_or_en | input | NPT (5) | terms that enter the OR sum |
| cfg_cas_en | input | 1 | include cas_in in the sum |
| cfg_xor_sel | input | 2 | second XOR operand select |
| cfg_xor_pt | input | PT_W (3) | term index for the XOR operand |
| cfg_d_sel | input | 2 | register data source |
| cfg_d_pt | input | PT_W (3) | term index for register data |
| cfg_aux_pt | input | PT_W (3) | term index for K / R input |
| cfg_mode | input | 3 | register personality |
| cfg_clk_sel | input | CS_W (2) | clock source select |
| cfg_clk_pt | input | PT_W (3) | term index for the term clock |
| cfg_ce_en | input | 1 | enable the clock enable term |
| cfg_ce_pt | input | PT_W (3) | term index for the clock enable |
| cfg_ar_sel | input | 2 | clear source select |
| cfg_ar_pt | input | PT_W (3) | term index for the clear |
| cfg_ap_en | input | 1 | enable the preset term |
| cfg_ap_pt | input | PT_W (3) | term index for the preset |
| cfg_out_reg | input | 1 | pin output registered when 1 |
| cfg_fb_reg | input | 1 | feedback registered when 1 |
| cfg_oe_sel | input | 3 | output enable source select |
| cfg_oe_pt | input | PT_W (3) | term index for the output enable |
| cfg_fold_pt | input | PT_W (3) | term index for the foldback |
| pin_out | output | 1 | pin data |
| pin_oe | output | 1 | pin output enable |
| fb_out | output | 1 | feedback to the array |
| fold_out | output | 1 | inverted foldback term |
| cas_out | output | 1 | OR sum toward the next cell |

## Verification
Directed patterns probe the terms one at a time. Inputs that satisfy only the true literal, only the complement literal, both, or neither show whether the mask polarity is right. An out-of-range index shows the zero fill. The register is driven with source waveforms that rise, stay high and fall. These separate edge detection from level sensing, and the latch from the flip-flop. The enable term is swept low and high, and the term clock is run with the enable low, to expose whether the enable is wrongly honoured. Clear and preset are raised together and singly against a pending clock event, to show priority. A long random phase then mixes every mode, source, mask and output choice, so that cross-effects between the term roles show up as mismatches.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [2:0] {
        MODE_D     = 3'd0,
        MODE_T     = 3'd1,
        MODE_JK    = 3'd2,
        MODE_SR    = 3'd3,
        MODE_LATCH = 3'd4
    } reg_mode_e;

    typedef struct packed {
        logic q;     // stored bit
        logic src;   // selected clock source level seen at the last clk edge
    } cell_state_t;

    // Next stored value for an edge-triggered personality on a clock event.
    function automatic logic edge_next(input logic [2:0] mode, input logic q,
                                       input logic d, input logic aux);
        logic r;
        case (mode)
            MODE_T:  r = q ^ d;
            MODE_JK: begin
                case ({d, aux})
                    2'b10:   r = 1'b1;
                    2'b01:   r = 1'b0;
                    2'b11:   r = ~q;
                    default: r = q;
                endcase
            end
            MODE_SR: begin
                case ({d, aux})
                    2'b10:   r = 1'b1;
                    2'b01:   r = 1'b0;
                    default: r = q;
                endcase
            end
            default: r = d;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mc_pterms.sv
module mc_pterms #(
    parameter int N_IN = 8,
    parameter int NPT  = 5
) (
    input  logic [N_IN-1:0]     arr,
    input  logic [NPT*N_IN-1:0] tru,
    input  logic [NPT*N_IN-1:0] cmp,
    output logic [NPT-1:0]      pt
);
    for (genvar k = 0; k < NPT; k++) begin : g_term
        logic [N_IN-1:0] tmask;
        logic [N_IN-1:0] cmask;
        assign tmask = tru[k*N_IN +: N_IN];
        assign cmask = cmp[k*N_IN +: N_IN];
        // A literal not selected contributes a 1 to the AND.
        assign pt[k] = (&(~tmask | arr)) & (&(~cmask | ~arr));
    end
endmodule

// File: rtl/mc_sum.sv
module mc_sum #(
    parameter int NPT = 5
) (
    input  logic [NPT-1:0] pt,
    input  logic [NPT-1:0] or_en,
    input  logic           cas_en,
    input  logic           cas_in,
    input  logic [1:0]     xor_sel,
    input  logic           xor_term,
    output logic           sum,
    output logic           xor_out
);
    logic xop;

    always_comb begin
        sum = cas_en & cas_in;
        for (int k = 0; k < NPT; k++) begin
            sum = sum | (or_en[k] & pt[k]);
        end
        case (xor_sel)
            2'd0:    xop = 1'b0;
            2'd1:    xop = 1'b1;
            default: xop = xor_term;
        endcase
        xor_out = sum ^ xop;
    end
endmodule

// File: rtl/mc_reg.sv
module mc_reg
    import mc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       src,
    input  logic       ce,
    input  logic       d,
    input  logic       aux,
    input  logic [2:0] mode,
    input  logic       clr,
    input  logic       pre,
    output logic       q_eff,
    output logic       q_state,
    output logic       clk_edge
);
    cell_state_t cur_q;
    cell_state_t nxt_d;
    logic        is_latch;
    logic        open_w;

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.src = src;
        is_latch = (mode == MODE_LATCH);
        clk_edge = src & ~cur_q.src;
        open_w   = is_latch & src & ce;
        if (clr) begin
            nxt_d.q = 1'b0;
        end else if (pre) begin
            nxt_d.q = 1'b1;
        end else if (is_latch) begin
            if (open_w) nxt_d.q = d;
        end else if (clk_edge & ce) begin
            nxt_d.q = edge_next(mode, cur_q.q, d, aux);
        end
        // Controls and latch transparency reach the output without waiting for clk.
        if (clr)         q_eff = 1'b0;
        else if (pre)    q_eff = 1'b1;
        else if (open_w) q_eff = d;
        else             q_eff = cur_q.q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign q_state = cur_q.q;
endmodule

// File: rtl/pterm_macrocell.sv
module pterm_macrocell #(
    parameter int N_IN   = 8,
    parameter int NPT    = 5,
    parameter int N_GCLK = 3,
    localparam int PT_W  = $clog2(NPT),
    localparam int CS_W  = $clog2(N_GCLK + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_IN-1:0]      arr_in,
    input  logic                 pin_in,
    input  logic                 cas_in,
    input  logic [N_GCLK-1:0]    gclk,
    input  logic                 gclr,
    input  logic [1:0]           goe,
    input  logic [NPT*N_IN-1:0]  cfg_tru,
    input  logic [NPT*N_IN-1:0]  cfg_cmp,
    input  logic [NPT-1:0]       cfg_or_en,
    input  logic                 cfg_cas_en,
    input  logic [1:0]           cfg_xor_sel,
    input  logic [PT_W-1:0]      cfg_xor_pt,
    input  logic [1:0]           cfg_d_sel,
    input  logic [PT_W-1:0]      cfg_d_pt,
    input  logic [PT_W-1:0]      cfg_aux_pt,
    input  logic [2:0]           cfg_mode,
    input  logic [CS_W-1:0]      cfg_clk_sel,
    input  logic [PT_W-1:0]      cfg_clk_pt,
    input  logic                 cfg_ce_en,
    input  logic [PT_W-1:0]      cfg_ce_pt,
    input  logic [1:0]           cfg_ar_sel,
    input  logic [PT_W-1:0]      cfg_ar_pt,
    input  logic                 cfg_ap_en,
    input  logic [PT_W-1:0]      cfg_ap_pt,
    input  logic                 cfg_out_reg,
    input  logic                 cfg_fb_reg,
    input  logic [2:0]           cfg_oe_sel,
    input  logic [PT_W-1:0]      cfg_oe_pt,
    input  logic [PT_W-1:0]      cfg_fold_pt,
    output logic                 pin_out,
    output logic                 pin_oe,
    output logic                 fb_out,
    output logic                 fold_out,
    output logic                 cas_out
);
    localparam int PT_N = 1 << PT_W;
    localparam int CS_N = 1 << CS_W;
    localparam logic [CS_W-1:0] CS_TERM = CS_W'(N_GCLK);

    logic [NPT-1:0]  pt;
    logic [PT_N-1:0] pt_ext;
    logic [CS_N-1:0] gclk_ext;
    logic            sum_w;
    logic            xor_w;
    logic            reg_d;
    logic            reg_aux;
    logic            reg_src;
    logic            reg_ce;
    logic            clr_act;
    logic            pre_act;
    logic            q_eff;
    logic            q_state;
    logic            reg_edge;

    function automatic logic pick(input logic [PT_N-1:0] v, input logic [PT_W-1:0] idx);
        return v[idx];
    endfunction

    mc_pterms #(.N_IN(N_IN), .NPT(NPT)) i_terms (
        .arr (arr_in),
        .tru (cfg_tru),
        .cmp (cfg_cmp),
        .pt  (pt)
    );

    // Indices past the last term land on zero padding.
    assign pt_ext   = PT_N'(pt);
    assign gclk_ext = CS_N'(gclk);

    mc_sum #(.NPT(NPT)) i_sum (
        .pt       (pt),
        .or_en    (cfg_or_en),
        .cas_en   (cfg_cas_en),
        .cas_in   (cas_in),
        .xor_sel  (cfg_xor_sel),
        .xor_term (pick(pt_ext, cfg_xor_pt)),
        .sum      (sum_w),
        .xor_out  (xor_w)
    );

    always_comb begin
        case (cfg_d_sel)
            2'd0:    reg_d = xor_w;
            2'd1:    reg_d = pick(pt_ext, cfg_d_pt);
            default: reg_d = pin_in;
        endcase
        reg_aux = pick(pt_ext, cfg_aux_pt);
        if (cfg_clk_sel < CS_TERM) begin
            reg_src = gclk_ext[cfg_clk_sel];
            reg_ce  = cfg_ce_en ? pick(pt_ext, cfg_ce_pt) : 1'b1;
        end else begin
            reg_src = pick(pt_ext, cfg_clk_pt);
            reg_ce  = 1'b1;
        end
        case (cfg_ar_sel)
            2'd0:    clr_act = 1'b0;
            2'd1:    clr_act = gclr;
            2'd2:    clr_act = pick(pt_ext, cfg_ar_pt);
            default: clr_act = gclr | pick(pt_ext, cfg_ar_pt);
        endcase
        pre_act = cfg_ap_en & pick(pt_ext, cfg_ap_pt);
    end

    mc_reg i_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (reg_src),
        .ce       (reg_ce),
        .d        (reg_d),
        .aux      (reg_aux),
        .mode     (cfg_mode),
        .clr      (clr_act),
        .pre      (pre_act),
        .q_eff    (q_eff),
        .q_state  (q_state),
        .clk_edge (reg_edge)
    );

    always_comb begin
        pin_out  = cfg_out_reg ? q_eff : xor_w;
        fb_out   = cfg_fb_reg  ? q_eff : xor_w;
        fold_out = ~pick(pt_ext, cfg_fold_pt);
        cas_out  = sum_w;
        case (cfg_oe_sel)
            3'd0:    pin_oe = 1'b1;
            3'd1:    pin_oe = 1'b0;
            3'd2:    pin_oe = goe[0];
            3'd3:    pin_oe = goe[1];
            default: pin_oe = pick(pt_ext, cfg_oe_pt);
        endcase
    end
endmodule

// File: rtl/mc_checker.sv
module mc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] cfg_mode,
    input logic [2:0] cfg_oe_sel,
    input logic       pin_oe,
    input logic       reg_edge,
    input logic       reg_ce,
    input logic       reg_d,
    input logic       clr_act,
    input logic       pre_act,
    input logic       q_state
);
    p_clr_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act |=> (q_state == 1'b0));

    p_preset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_act && !clr_act) |=> (q_state == 1'b1));

    p_dload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 3'd0 && reg_edge && reg_ce && !clr_act && !pre_act)
        |=> (q_state == $past(reg_d)));

    p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 3'd1 && reg_edge && reg_ce && reg_d && !clr_act && !pre_act)
        |=> (q_state != $past(q_state)));

    p_ce_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode != 3'd4 && !reg_ce && !clr_act && !pre_act)
        |=> (q_state == $past(q_state)));

    p_no_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode != 3'd4 && !reg_edge && !clr_act && !pre_act)
        |=> (q_state == $past(q_state)));

    p_oe_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_oe_sel == 3'd1) |-> !pin_oe);

    p_oe_on_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_oe_sel == 3'd0) |-> pin_oe);
endmodule

bind pterm_macrocell mc_checker u_mc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_mode   (cfg_mode),
    .cfg_oe_sel (cfg_oe_sel),
    .pin_oe     (pin_oe),
    .reg_edge   (reg_edge),
    .reg_ce     (reg_ce),
    .reg_d      (reg_d),
    .clr_act    (clr_act),
    .pre_act    (pre_act),
    .q_state    (q_state)
);

// File: tb/test_pterm_macrocell.sv
module test_pterm_macrocell;
    localparam int CLK_PERIOD = 10;
    localparam int N_IN = 8;
    localparam int NPT  = 5;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic rst_n;
    logic [N_IN-1:0] arr_in;
    logic pin_in, cas_in, gclr;
    logic [2:0] gclk;
    logic [1:0] goe;
    logic [N_IN-1:0] tru_m [NPT];
    logic [N_IN-1:0] cmp_m [NPT];
    logic [NPT*N_IN-1:0] cfg_tru, cfg_cmp;
    logic [NPT-1:0] cfg_or_en;
    logic cfg_cas_en, cfg_ce_en, cfg_ap_en, cfg_out_reg, cfg_fb_reg;
    logic [1:0] cfg_xor_sel, cfg_d_sel, cfg_ar_sel, cfg_clk_sel;
    logic [2:0] cfg_mode, cfg_oe_sel;
    logic [2:0] cfg_xor_pt, cfg_d_pt, cfg_aux_pt, cfg_clk_pt, cfg_ce_pt;
    logic [2:0] cfg_ar_pt, cfg_ap_pt, cfg_oe_pt, cfg_fold_pt;
    logic pin_out, pin_oe, fb_out, fold_out, cas_out;

    always_comb begin
        for (int k = 0; k < NPT; k++) begin
            cfg_tru[k*N_IN +: N_IN] = tru_m[k];
            cfg_cmp[k*N_IN +: N_IN] = cmp_m[k];
        end
    end

    pterm_macrocell i_pterm_macrocell (
        .clk(clk), .rst_n(rst_n), .arr_in(arr_in), .pin_in(pin_in), .cas_in(cas_in),
        .gclk(gclk), .gclr(gclr), .goe(goe), .cfg_tru(cfg_tru), .cfg_cmp(cfg_cmp),
        .cfg_or_en(cfg_or_en), .cfg_cas_en(cfg_cas_en), .cfg_xor_sel(cfg_xor_sel),
        .cfg_xor_pt(cfg_xor_pt), .cfg_d_sel(cfg_d_sel), .cfg_d_pt(cfg_d_pt),
        .cfg_aux_pt(cfg_aux_pt), .cfg_mode(cfg_mode), .cfg_clk_sel(cfg_clk_sel),
        .cfg_clk_pt(cfg_clk_pt), .cfg_ce_en(cfg_ce_en), .cfg_ce_pt(cfg_ce_pt),
        .cfg_ar_sel(cfg_ar_sel), .cfg_ar_pt(cfg_ar_pt), .cfg_ap_en(cfg_ap_en),
        .cfg_ap_pt(cfg_ap_pt), .cfg_out_reg(cfg_out_reg), .cfg_fb_reg(cfg_fb_reg),
        .cfg_oe_sel(cfg_oe_sel), .cfg_oe_pt(cfg_oe_pt), .cfg_fold_pt(cfg_fold_pt),
        .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out), .fold_out(fold_out),
        .cas_out(cas_out)
    );

    int  checks = 0;
    int  fails  = 0;
    bit  reported = 0;
    bit  mq = 0;
    bit  mprev = 0;

    // ---------------- reference model from the requirements ----------------
    function automatic bit f_pt(input logic [2:0] k);
        if (k >= NPT) return 1'b0;                                  // R1 zero fill
        return ((arr_in & tru_m[k]) == tru_m[k]) && ((~arr_in & cmp_m[k]) == cmp_m[k]);
    endfunction
    function automatic bit f_sum();
        bit s = cfg_cas_en && cas_in;
        for (int k = 0; k < NPT; k++) if (cfg_or_en[k] && f_pt(3'(k))) s = 1'b1;
        return s;
    endfunction
    function automatic bit f_xor();
        bit op = (cfg_xor_sel == 2'd0) ? 1'b0 : (cfg_xor_sel == 2'd1) ? 1'b1 : f_pt(cfg_xor_pt);
        return f_sum() ^ op;
    endfunction
    function automatic bit f_data();
        if (cfg_d_sel == 2'd0) return f_xor();
        if (cfg_d_sel == 2'd1) return f_pt(cfg_d_pt);
        return pin_in;
    endfunction
    function automatic bit f_src();
        return (cfg_clk_sel == 2'd3) ? f_pt(cfg_clk_pt) : gclk[cfg_clk_sel];
    endfunction
    function automatic bit f_ce();
        return (cfg_clk_sel != 2'd3 && cfg_ce_en) ? f_pt(cfg_ce_pt) : 1'b1;
    endfunction
    function automatic bit f_clr();
        case (cfg_ar_sel)
            2'd0: return 1'b0;
            2'd1: return gclr;
            2'd2: return f_pt(cfg_ar_pt);
            default: return gclr || f_pt(cfg_ar_pt);
        endcase
    endfunction
    function automatic bit f_pre();
        return cfg_ap_en && f_pt(cfg_ap_pt);
    endfunction
    function automatic bit f_open();
        return cfg_mode == 3'd4 && f_src() && f_ce();
    endfunction
    function automatic bit f_q();
        if (f_clr()) return 1'b0;
        if (f_pre()) return 1'b1;
        if (f_open()) return f_data();
        return mq;
    endfunction
    function automatic bit f_next();
        bit d = f_data();
        bit a = f_pt(cfg_aux_pt);
        if (f_clr()) return 1'b0;
        if (f_pre()) return 1'b1;
        if (cfg_mode == 3'd4) return f_open() ? d : mq;
        if (!(f_src() && !mprev && f_ce())) return mq;
        case (cfg_mode)
            3'd1: return mq ^ d;
            3'd2: return (d && a) ? !mq : d ? 1'b1 : a ? 1'b0 : mq;
            3'd3: return (d && !a) ? 1'b1 : (a && !d) ? 1'b0 : mq;
            default: return d;
        endcase
    endfunction
    function automatic bit f_oe();
        case (cfg_oe_sel)
            3'd0: return 1'b1;
            3'd1: return 1'b0;
            3'd2: return goe[0];
            3'd3: return goe[1];
            default: return f_pt(cfg_oe_pt);
        endcase
    endfunction

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cmp_all(input string tag);
        #1;
        chk(tag, "pin_out", pin_out, cfg_out_reg ? f_q() : f_xor());
        chk(tag, "fb_out", fb_out, cfg_fb_reg ? f_q() : f_xor());
        chk("R2", "fold_out", fold_out, !f_pt(cfg_fold_pt));
        chk("R3", "cas_out", cas_out, f_sum());
        chk("R12", "pin_oe", pin_oe, f_oe());
    endtask

    task automatic tick();
        bit n = f_next();
        bit s = f_src();
        @(posedge clk);
        #1;
        mq = n;
        mprev = s;
    endtask

    task automatic cyc(input string tag);
        cmp_all(tag);
        tick();
    endtask

    task automatic cfg_default();
        for (int k = 0; k < NPT; k++) begin tru_m[k] = '0; cmp_m[k] = '0; end
        cfg_or_en = '0; cfg_cas_en = 0; cfg_xor_sel = 0; cfg_xor_pt = 0;
        cfg_d_sel = 0; cfg_d_pt = 0; cfg_aux_pt = 0; cfg_mode = 0;
        cfg_clk_sel = 0; cfg_clk_pt = 0; cfg_ce_en = 0; cfg_ce_pt = 0;
        cfg_ar_sel = 0; cfg_ar_pt = 0; cfg_ap_en = 0; cfg_ap_pt = 0;
        cfg_out_reg = 1; cfg_fb_reg = 0; cfg_oe_sel = 0; cfg_oe_pt = 0; cfg_fold_pt = 0;
        arr_in = '0; pin_in = 0; cas_in = 0; gclk = '0; gclr = 0; goe = '0;
    endtask

    task automatic finish_run();
        if (!reported) begin
            reported = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        end
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired t=%0t", $time);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        cfg_default();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        // R13: stored bit is 0 under reset
        chk("R13", "pin_out in reset", pin_out, 1'b0);
        mq = 0; mprev = 0;
        rst_n = 1;
        @(posedge clk); #1;
        chk("R13", "pin_out after reset", pin_out, 1'b0);

        // R1: literal polarity, empty mask, out-of-range index
        cfg_out_reg = 0; cfg_or_en = 5'b00001;
        tru_m[0] = 8'h01; cmp_m[0] = 8'h02;
        foreach (tru_m[i]) ;
        arr_in = 8'h00; cyc("R1");
        arr_in = 8'h01; cyc("R1");
        arr_in = 8'h03; cyc("R1");
        arr_in = 8'h02; cyc("R1");
        arr_in = 8'hFD; cyc("R1");
        cfg_fold_pt = 3'd6; cyc("R1");
        cfg_fold_pt = 3'd4; cyc("R1");
        cfg_or_en = 5'b00010; cyc("R1");

        // R4: XOR polarity and term operand
        cfg_or_en = 5'b00001; tru_m[1] = 8'h04;
        cfg_xor_sel = 1; arr_in = 8'h01; cyc("R4");
        arr_in = 8'h00; cyc("R4");
        cfg_xor_sel = 2; cfg_xor_pt = 1; arr_in = 8'h05; cyc("R4");
        arr_in = 8'h04; cyc("R4");
        cfg_xor_pt = 3'd7; cyc("R4");

        // R5 with R7 global clock 1: data from the pin, edge only
        cfg_out_reg = 1; cfg_xor_sel = 0; cfg_d_sel = 2; cfg_clk_sel = 1;
        for (int i = 0; i < 12; i++) begin
            gclk[1] = i[0]; pin_in = i[1] ^ i[2]; cyc("R5");
        end
        cfg_d_sel = 0; arr_in = 8'h01;
        for (int i = 0; i < 6; i++) begin gclk[1] = i[0]; cyc("R5"); end

        // R7: term clock, data from a term
        cfg_clk_sel = 3; cfg_clk_pt = 2; tru_m[2] = 8'h80;
        cfg_d_sel = 1; cfg_d_pt = 3; tru_m[3] = 8'h40;
        for (int i = 0; i < 12; i++) begin
            arr_in = {i[0], i[2] ^ i[1], 6'h00}; cyc("R7");
        end

        // R8: latch transparency and hold
        cfg_mode = 4; cfg_clk_sel = 0; cfg_d_sel = 2;
        for (int i = 0; i < 16; i++) begin
            gclk[0] = i[2]; pin_in = i[0]; cyc("R8");
        end

        // R9: clock enable term blocks events; ignored with term clock
        cfg_mode = 0; cfg_ce_en = 1; cfg_ce_pt = 4; tru_m[4] = 8'h20;
        for (int i = 0; i < 16; i++) begin
            arr_in = {2'b00, i[3], 5'h00}; gclk[0] = i[0]; pin_in = i[1]; cyc("R9");
        end
        cfg_clk_sel = 3; cfg_clk_pt = 2; arr_in = 8'h00;
        for (int i = 0; i < 8; i++) begin
            arr_in = {i[0], 7'h00}; pin_in = i[1]; cyc("R9");
        end
        cfg_mode = 4; cfg_clk_sel = 0; arr_in = 8'h00; gclk[0] = 1;
        for (int i = 0; i < 4; i++) begin pin_in = i[0]; cyc("R9"); end

        // R10: clear and preset, alone and together
        cfg_mode = 0; cfg_ce_en = 0; cfg_ar_sel = 3; cfg_ar_pt = 1;
        cfg_ap_en = 1; cfg_ap_pt = 3; tru_m[1] = 8'h04; tru_m[3] = 8'h40;
        pin_in = 1;
        arr_in = 8'h40; gclk[0] = 0; cyc("R10");
        arr_in = 8'h44; cyc("R10");
        gclr = 1; arr_in = 8'h40; gclk[0] = 1; cyc("R10");
        gclr = 0; gclk[0] = 0; arr_in = 8'h00; cyc("R10");
        arr_in = 8'h40; cyc("R10");
        cfg_ar_sel = 2; arr_in = 8'h44; cyc("R10");
        cfg_ar_sel = 0; arr_in = 8'h04; cyc("R10");

        // R11: output and feedback chosen independently
        cfg_ap_en = 0; cfg_mode = 1; cfg_d_sel = 2; pin_in = 1; cfg_or_en = 5'b00001;
        tru_m[0] = 8'h01; cmp_m[0] = 8'h00;
        for (int i = 0; i < 12; i++) begin
            cfg_out_reg = i[1]; cfg_fb_reg = i[2]; gclk[0] = i[0]; arr_in = {7'h00, i[3]};
            cyc("R11");
        end

        // R6: random mix of modes, sources and masks
        for (int n = 0; n < 4000; n++) begin
            if (n % 8 == 0) begin
                for (int k = 0; k < NPT; k++) begin
                    tru_m[k] = 8'($urandom & $urandom & $urandom);
                    cmp_m[k] = 8'($urandom & $urandom & $urandom) & ~tru_m[k];
                end
                cfg_or_en = 5'($urandom); cfg_cas_en = 1'($urandom);
                cfg_xor_sel = 2'($urandom); cfg_xor_pt = 3'($urandom);
                cfg_d_sel = 2'($urandom); cfg_d_pt = 3'($urandom);
                cfg_aux_pt = 3'($urandom); cfg_mode = 3'($urandom);
                cfg_clk_sel = 2'($urandom); cfg_clk_pt = 3'($urandom);
                cfg_ce_en = 1'($urandom); cfg_ce_pt = 3'($urandom);
                cfg_ar_sel = ($urandom % 4 == 0) ? 2'($urandom) : 2'd0;
                cfg_ar_pt = 3'($urandom);
                cfg_ap_en = ($urandom % 4 == 0); cfg_ap_pt = 3'($urandom);
                cfg_out_reg = 1'($urandom); cfg_fb_reg = 1'($urandom);
                cfg_oe_sel = 3'($urandom); cfg_oe_pt = 3'($urandom);
                cfg_fold_pt = 3'($urandom);
            end
            arr_in = 8'($urandom); pin_in = 1'($urandom); cas_in = 1'($urandom);
            gclk = 3'($urandom); gclr = ($urandom % 8 == 0); goe = 2'($urandom);
            cyc("R6");
        end

        finish_run();
    end
endmodule